// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block keeps the control-flow state of one warp: a group of lanes that share one program counter. It holds a small stack. Each entry records the lanes that are active on one path, the PC at which that path continues, and the PC at which the path joins its sibling again. The issue stage always reads the PC and the lane mask from the top entry. After each instruction the execution side reports one step. A step either gives the next sequential PC or resolves a branch, giving a fall-through PC, a target PC, the join PC and a per-lane taken mask.

When a branch sends some active lanes one way and the rest the other way, the parent entry is parked at the join PC. Two children are pushed: the not-taken child first, then the taken child, so the taken path runs first. A child whose continuation PC reaches its own join PC is removed by the block itself. That exposes the next path, or the parked parent. The bottom entry covers every lane and is never removed.

Steps arrive on a valid/ready port. `step_ready` is low in any cycle in which the top entry is being removed. While `step_valid` is high and `step_ready` is low, the producer must hold every step field steady. A step is taken only in a cycle where both signals are high. `iss_valid` is low in exactly those removal cycles.

Top module: `rs_reconv_stack`

## Requirements
- R1: After reset the stack holds one entry: `iss_pc` equals the START_PC parameter, `iss_mask` is all ones, `iss_valid` is 1 and `ovf_err` is 0.
- R2: An accepted step with `step_is_branch`=0 sets `iss_pc` to `step_next_pc` from the next cycle on and leaves `iss_mask` unchanged.
- R3: A branch is uniform when its effective taken set (see R5) is empty or equals the active mask. A uniform branch pushes nothing. `iss_pc` becomes `step_target_pc` when all active lanes are taken, or `step_next_pc` when none are, and `iss_mask` is unchanged.
- R4: A divergent branch sets the top entry's continuation PC to `step_reconv_pc` and pushes two entries, both with that join PC: first {`step_next_pc`, the not-taken lanes}, then {`step_target_pc`, the taken lanes}. In the next cycle `iss_pc`/`iss_mask` show the taken child. The two child masks share no lane, and together they equal the parent mask.
- R5: Bits of `step_taken` for lanes outside the current active mask have no effect.
- R6: A top entry other than the bottom one is removed when its continuation PC equals its join PC. The removal takes one cycle, during which `iss_valid` and `step_ready` are 0. The entry below then becomes the top. If that entry also matches its own join PC, it is removed in the same way in the following cycle.
- R7: The bottom entry is never removed, whatever PC it is steered to.
- R8: A divergent branch that would need more than DEPTH entries is consumed without changing the stack. `ovf_err` is 1 during the single cycle after it is accepted.
- R9: While `step_ready` is 0, a held step is not consumed. It is accepted once `step_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_valid | input | 1 | Step report present |
| step_ready | output | 1 | Step accepted when high together with step_valid |
| step_is_branch | input | 1 | Step resolves a branch |
| step_next_pc | input | PC_W | Sequential / fall-through PC |
| step_target_pc | input | PC_W | Branch target PC |
| step_reconv_pc | input | PC_W | Join PC of the branch |
| step_taken | input | LANES | Per-lane taken outcome |
| iss_valid | output | 1 | Issue PC and mask are usable |
| iss_pc | output | PC_W | PC of the top entry |
| iss_mask | output | LANES | Active lanes of the top entry |
| ovf_err | output | 1 | One-cycle flag for a dropped divergent branch |

## Verification
Sequential steps and uniform branches, taken and not taken, show that a PC update never grows the stack. A simple if/else split separates the order in which the two paths run and checks their lane sets. A nested split shows that an exposed parent is resumed at its join PC. A second nested split, whose two levels share one join PC, shows that two removals happen back to back. A taken mask with stray bits outside the active lanes checks that those bits are masked off. Filling the stack to DEPTH and then issuing a further divergent branch separates a dropped push from a corrupted one. Holding a step during a removal cycle checks back-pressure.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Operation applied to the stack storage in a cycle
  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_ADVANCE = 2'd1,
    OP_SPLIT   = 2'd2,
    OP_POP     = 2'd3
  } stk_op_e;
endpackage

// File: rtl/rs_split.sv
module rs_split #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] act_mask,
  input  logic [LANES-1:0] taken,
  output logic [LANES-1:0] tk_mask,
  output logic [LANES-1:0] nt_mask,
  output logic             divergent,
  output logic             all_taken
);
  // Lanes outside the active set are discarded before any decision
  always_comb begin
    tk_mask   = act_mask & taken;
    nt_mask   = act_mask & ~taken;
    divergent = (tk_mask != '0) && (nt_mask != '0);
    all_taken = (nt_mask == '0);
  end
endmodule

// File: rtl/rs_stack_mem.sv
module rs_stack_mem
  import rs_pkg::*;
#(
  parameter int          LANES    = 8,
  parameter int          PC_W     = 32,
  parameter int          DEPTH    = 8,
  parameter int          SP_W     = 4,
  parameter logic [31:0] START_PC = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op,
  input  logic [PC_W-1:0]  wr_next,
  input  logic [PC_W-1:0]  sp_join,
  input  logic [PC_W-1:0]  nt_next,
  input  logic [LANES-1:0] nt_mask,
  input  logic [PC_W-1:0]  tk_next,
  input  logic [LANES-1:0] tk_mask,
  output logic [SP_W-1:0]  count,
  output logic [PC_W-1:0]  top_join,
  output logic [PC_W-1:0]  top_next,
  output logic [LANES-1:0] top_mask
);
  logic [SP_W-1:0]  cnt_q;
  logic [SP_W-1:0]  top_ix;
  logic [PC_W-1:0]  join_a [DEPTH];
  logic [PC_W-1:0]  next_a [DEPTH];
  logic [LANES-1:0] mask_a [DEPTH];

  assign top_ix = cnt_q - 1'b1;
  assign count  = cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [SP_W-1:0] IDX = SP_W'(i);
    logic [PC_W-1:0]  join_r;
    logic [PC_W-1:0]  next_r;
    logic [LANES-1:0] mask_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        join_r <= '0;
        next_r <= (i == 0) ? PC_W'(START_PC) : '0;
        mask_r <= (i == 0) ? '1 : '0;
      end else begin
        case (op)
          OP_ADVANCE: if (IDX == top_ix) next_r <= wr_next;
          OP_SPLIT: begin
            if (IDX == top_ix) begin
              next_r <= sp_join;
            end else if (IDX == top_ix + SP_W'(1)) begin
              join_r <= sp_join;
              next_r <= nt_next;
              mask_r <= nt_mask;
            end else if (IDX == top_ix + SP_W'(2)) begin
              join_r <= sp_join;
              next_r <= tk_next;
              mask_r <= tk_mask;
            end
          end
          default: ;
        endcase
      end
    end

    assign join_a[i] = join_r;
    assign next_a[i] = next_r;
    assign mask_a[i] = mask_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= SP_W'(1);
    else if (op == OP_SPLIT)  cnt_q <= cnt_q + SP_W'(2);
    else if (op == OP_POP)    cnt_q <= cnt_q - SP_W'(1);
  end

  always_comb begin
    top_join = '0;
    top_next = '0;
    top_mask = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (SP_W'(i) == top_ix) begin
        top_join = join_a[i];
        top_next = next_a[i];
        top_mask = mask_a[i];
      end
    end
  end
endmodule

// File: rtl/rs_reconv_stack.sv
module rs_reconv_stack
  import rs_pkg::*;
#(
  parameter int          LANES    = 8,
  parameter int          PC_W     = 32,
  parameter int          DEPTH    = 8,
  parameter logic [31:0] START_PC = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid,
  output logic             step_ready,
  input  logic             step_is_branch,
  input  logic [PC_W-1:0]  step_next_pc,
  input  logic [PC_W-1:0]  step_target_pc,
  input  logic [PC_W-1:0]  step_reconv_pc,
  input  logic [LANES-1:0] step_taken,
  output logic             iss_valid,
  output logic [PC_W-1:0]  iss_pc,
  output logic [LANES-1:0] iss_mask,
  output logic             ovf_err
);
  localparam int              SP_W        = $clog2(DEPTH + 1);
  localparam logic [SP_W-1:0] SPLIT_LIMIT = SP_W'(DEPTH - 2);

  stk_op_e          op;
  logic [SP_W-1:0]  depth_w;
  logic [PC_W-1:0]  top_join, top_next, wr_next;
  logic [LANES-1:0] top_mask, tk_m, nt_m;
  logic             div_w, all_tk, room_w, pop_pend, acc, ovf_q;

  rs_split #(.LANES(LANES)) u_split (
    .act_mask (top_mask),
    .taken    (step_taken),
    .tk_mask  (tk_m),
    .nt_mask  (nt_m),
    .divergent(div_w),
    .all_taken(all_tk)
  );

  rs_stack_mem #(
    .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .SP_W(SP_W), .START_PC(START_PC)
  ) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .wr_next (wr_next),
    .sp_join (step_reconv_pc),
    .nt_next (step_next_pc),
    .nt_mask (nt_m),
    .tk_next (step_target_pc),
    .tk_mask (tk_m),
    .count   (depth_w),
    .top_join(top_join),
    .top_next(top_next),
    .top_mask(top_mask)
  );

  assign pop_pend   = (depth_w != SP_W'(1)) && (top_next == top_join);
  assign step_ready = !pop_pend;
  assign iss_valid  = !pop_pend;
  assign iss_pc     = top_next;
  assign iss_mask   = top_mask;
  assign acc        = step_valid && step_ready;
  assign room_w     = depth_w <= SPLIT_LIMIT;
  assign ovf_err    = ovf_q;

  always_comb begin
    wr_next = step_next_pc;
    if (step_is_branch && all_tk) wr_next = step_target_pc;
    if (pop_pend)                             op = OP_POP;
    else if (!acc)                            op = OP_IDLE;
    else if (step_is_branch && div_w)         op = room_w ? OP_SPLIT : OP_IDLE;
    else                                      op = OP_ADVANCE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= acc && step_is_branch && div_w && !room_w;
  end
endmodule

// File: rtl/rs_reconv_stack_chk.sv
module rs_reconv_stack_chk #(
  parameter int LANES = 8,
  parameter int SP_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_valid,
  input logic             step_ready,
  input logic             step_is_branch,
  input logic             iss_valid,
  input logic [LANES-1:0] iss_mask,
  input logic             ovf_err,
  input logic [SP_W-1:0]  depth,
  input logic             divergent,
  input logic             room,
  input logic [LANES-1:0] tk_m,
  input logic [LANES-1:0] nt_m,
  input logic [LANES-1:0] act_m
);
  logic acc;
  assign acc = step_valid && step_ready;

  a_r7_bottom_full: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == SP_W'(1)) |-> (iss_mask == '1));

  a_r4_partition: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && step_is_branch && divergent) |-> (((tk_m & nt_m) == '0) && ((tk_m | nt_m) == act_m)));

  a_r4_split_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && step_is_branch && divergent && room) |=> (depth == $past(depth) + SP_W'(2)));

  a_r3_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !(step_is_branch && divergent)) |=> $stable(depth));

  a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    !step_ready |=> (depth == $past(depth) - SP_W'(1)));

  a_r6_pop_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    !step_ready |-> !iss_valid);

  a_r8_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && step_is_branch && divergent && !room) |=> (ovf_err && $stable(depth)));

  a_r4_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_mask != '0));
endmodule

bind rs_reconv_stack rs_reconv_stack_chk #(.LANES(LANES), .SP_W(SP_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .step_valid    (step_valid),
  .step_ready    (step_ready),
  .step_is_branch(step_is_branch),
  .iss_valid     (iss_valid),
  .iss_mask      (iss_mask),
  .ovf_err       (ovf_err),
  .depth         (depth_w),
  .divergent     (div_w),
  .room          (room_w),
  .tk_m          (tk_m),
  .nt_m          (nt_m),
  .act_m         (top_mask)
);

// File: tb/rs_reconv_stack_tb.sv
`timescale 1ns/1ps
module rs_reconv_stack_tb_top;
  localparam int LANES = 4;
  localparam int PC_W  = 16;
  localparam int DEPTH = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             step_valid = 1'b0;
  logic             step_ready;
  logic             step_is_branch = 1'b0;
  logic [PC_W-1:0]  step_next_pc = '0;
  logic [PC_W-1:0]  step_target_pc = '0;
  logic [PC_W-1:0]  step_reconv_pc = '0;
  logic [LANES-1:0] step_taken = '0;
  logic             iss_valid;
  logic [PC_W-1:0]  iss_pc;
  logic [LANES-1:0] iss_mask;
  logic             ovf_err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  rs_reconv_stack #(
    .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .START_PC(32'h100)
  ) dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_top(input string req, input logic [PC_W-1:0] pc, input logic [LANES-1:0] m);
    check({req, " valid"}, 32'(iss_valid), 32'd1);
    check({req, " pc"}, 32'(iss_pc), 32'(pc));
    check({req, " mask"}, 32'(iss_mask), 32'(m));
  endtask

  // Called at a negedge; returns at the negedge after acceptance
  task automatic send(input logic br, input logic [PC_W-1:0] nxt, input logic [PC_W-1:0] tgt,
                      input logic [PC_W-1:0] rj, input logic [LANES-1:0] tk);
    step_valid = 1'b1; step_is_branch = br; step_next_pc = nxt;
    step_target_pc = tgt; step_reconv_pc = rj; step_taken = tk;
    while (!step_ready) @(negedge clk);
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  task automatic wait_valid();
    while (!iss_valid) @(negedge clk);
  endtask

  task automatic t_reset();
    check_top("R1 reset", 16'h100, 4'b1111);
    check("R1 ovf_err", 32'(ovf_err), 32'd0);
  endtask

  task automatic t_sequential();
    send(1'b0, 16'h101, 16'h0, 16'h0, 4'b0000);
    check_top("R2 sequential", 16'h101, 4'b1111);
  endtask

  task automatic t_uniform();
    send(1'b1, 16'h102, 16'h200, 16'h300, 4'b1111);
    check_top("R3 all taken", 16'h200, 4'b1111);
    send(1'b1, 16'h201, 16'h250, 16'h300, 4'b0000);
    check_top("R3 none taken", 16'h201, 4'b1111);
    send(1'b0, 16'h300, 16'h0, 16'h0, 4'b0000);
    check_top("R7 bottom kept", 16'h300, 4'b1111);
  endtask

  task automatic t_if_else();
    send(1'b1, 16'h301, 16'h310, 16'h320, 4'b1001);
    check_top("R4 taken first", 16'h310, 4'b1001);
    send(1'b0, 16'h311, 16'h0, 16'h0, 4'b0000);
    check_top("R2 in path", 16'h311, 4'b1001);
    send(1'b0, 16'h320, 16'h0, 16'h0, 4'b0000);
    check("R6 pop bubble valid", 32'(iss_valid), 32'd0);
    check("R6 pop bubble ready", 32'(step_ready), 32'd0);
    // R9: step offered during the removal cycle is held, then accepted
    send(1'b0, 16'h302, 16'h0, 16'h0, 4'b0000);
    check_top("R9 held step", 16'h302, 4'b0110);
    send(1'b0, 16'h320, 16'h0, 16'h0, 4'b0000);
    wait_valid();
    check_top("R6 rejoin", 16'h320, 4'b1111);
  endtask

  task automatic t_nested();
    send(1'b1, 16'h330, 16'h400, 16'h500, 4'b1100);
    check_top("R4 outer", 16'h400, 4'b1100);
    send(1'b1, 16'h401, 16'h410, 16'h450, 4'b0111);
    check_top("R5 stray lanes", 16'h410, 4'b0100);
    send(1'b0, 16'h450, 16'h0, 16'h0, 4'b0000);
    wait_valid();
    check_top("R4 inner not-taken", 16'h401, 4'b1000);
    send(1'b0, 16'h450, 16'h0, 16'h0, 4'b0000);
    wait_valid();
    check_top("R4 parent resumed", 16'h450, 4'b1100);
    send(1'b0, 16'h500, 16'h0, 16'h0, 4'b0000);
    wait_valid();
    check_top("R4 outer not-taken", 16'h330, 4'b0011);
    send(1'b0, 16'h500, 16'h0, 16'h0, 4'b0000);
    wait_valid();
    check_top("R6 nested rejoin", 16'h500, 4'b1111);
  endtask

  task automatic t_cascade();
    send(1'b1, 16'h510, 16'h600, 16'h700, 4'b0011);
    send(1'b1, 16'h601, 16'h610, 16'h700, 4'b0001);
    check_top("R4 shared join", 16'h610, 4'b0001);
    send(1'b0, 16'h700, 16'h0, 16'h0, 4'b0000);
    wait_valid();
    check_top("R6 first pop", 16'h601, 4'b0010);
    send(1'b0, 16'h700, 16'h0, 16'h0, 4'b0000);
    check("R6 cascade 1", 32'(iss_valid), 32'd0);
    @(negedge clk);
    check("R6 cascade 2", 32'(iss_valid), 32'd0);
    @(negedge clk);
    check_top("R6 cascade end", 16'h510, 4'b1100);
    send(1'b0, 16'h700, 16'h0, 16'h0, 4'b0000);
    wait_valid();
    check_top("R6 cascade rejoin", 16'h700, 4'b1111);
  endtask

  task automatic t_overflow();
    send(1'b1, 16'h710, 16'h800, 16'h900, 4'b1110);
    send(1'b1, 16'h801, 16'h810, 16'h880, 4'b1100);
    check_top("R4 full stack", 16'h810, 4'b1100);
    send(1'b1, 16'h811, 16'h820, 16'h870, 4'b1000);
    check("R8 flag", 32'(ovf_err), 32'd1);
    check_top("R8 unchanged", 16'h810, 4'b1100);
    @(negedge clk);
    check("R8 one cycle", 32'(ovf_err), 32'd0);
    send(1'b1, 16'h811, 16'h850, 16'h870, 4'b1100);
    check_top("R3 uniform when full", 16'h850, 4'b1100);
    check("R8 no flag uniform", 32'(ovf_err), 32'd0);
    send(1'b0, 16'h880, 16'h0, 16'h0, 4'b0000);
    wait_valid();
    check_top("R8 sibling intact", 16'h801, 4'b0010);
    send(1'b0, 16'h880, 16'h0, 16'h0, 4'b0000);
    wait_valid();
    check_top("R8 parent intact", 16'h880, 4'b1110);
    send(1'b0, 16'h900, 16'h0, 16'h0, 4'b0000);
    wait_valid();
    check_top("R8 outer sibling", 16'h710, 4'b0001);
    send(1'b0, 16'h900, 16'h0, 16'h0, 4'b0000);
    wait_valid();
    check_top("R7 back to bottom", 16'h900, 4'b1111);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_uniform();
    t_if_else();
    t_nested();
    t_cascade();
    t_overflow();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule